// File: doc/BRIEF.md
# Multichannel Interrupt Request Encoder

This block collects interrupt requests from sixteen timer channels and presents them to a system bus as one prioritized request. Each channel has its own enable bit. One programmable request level and one base vector nibble are shared by every channel. A one-cycle pulse on a channel's request input sets that channel's pending latch. When at least one enabled channel is pending, the shared level appears on the level output. Level 0 turns all channel interrupts off. Level 7 is flagged as nonmaskable.

During an acknowledge cycle the block returns a vector number. Its upper nibble is the base field. Its lower nibble is the index of the lowest-numbered channel that is both pending and enabled. That channel's pending latch is cleared at the end of the acknowledge cycle. Configuration is loaded through two write strobes: one for the level and base fields, one for the 16-bit enable mask.

Top module: `irq_vec_enc`

## Requirements
- R1: After reset the level field, the base field and the enable mask are all zero and no request is pending, so lvl_o, nmi_o and vec_o read zero.
- R2: lvl_o equals the programmed level while at least one channel is both pending and enabled, and is 0 otherwise.
- R3: With the programmed level at 0, lvl_o stays 0 whatever channels are pending and enabled.
- R4: nmi_o is 1 exactly when lvl_o is 7.
- R5: Bit i of the enable mask gates channel i: with the bit at 0 the channel neither raises lvl_o nor wins an acknowledge.
- R6: vec_o carries the base field in bits 7:4 and the 4-bit index of the winning channel in bits 3:0.
- R7: Among channels that are pending and enabled, the lowest-numbered one is the winner.
- R8: A cycle with ack_i high clears the winner's pending latch at its closing clock edge and leaves every other latch unchanged.
- R9: A one-cycle pulse on req_i bit i keeps channel i pending until it is acknowledged. A new pulse in the same cycle as the acknowledge that would clear the channel keeps it pending.
- R10: An acknowledge with no channel pending and enabled changes no state, and vec_o bits 3:0 read 0 during it.
- R11: A pending latch on a disabled channel is kept, so setting its enable bit later raises lvl_o without a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the level and base fields |
| lvl_wdata_i | input | 3 | Request level to write |
| base_wdata_i | input | 4 | Base vector nibble to write |
| en_we_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | 16 | Enable mask to write, bit i for channel i |
| req_i | input | 16 | Request pulses, bit i for channel i |
| ack_i | input | 1 | Acknowledge cycle for the current winner |
| lvl_o | output | 3 | Shared request level driven to the bus |
| nmi_o | output | 1 | High when the driven level is nonmaskable |
| vec_o | output | 8 | Vector number for the current winner |

## Verification
Register writes and request pulses take effect at the clock edge that samples them, and lvl_o, nmi_o and vec_o follow combinationally, so each of these results is due one cycle after its stimulus. vec_o is also valid within the acknowledge cycle itself. The bench therefore reads vec_o before it raises ack_i. The bench drives every input on the falling edge, holds it for one full cycle, and samples outputs on the following falling edge, once the rising edge that applies the change has passed. Sweeps cover every single channel, every ordered pair of channels for priority, and every level value.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int LVL_W   = 3;
  localparam int BASE_W  = 4;
  localparam logic [LVL_W-1:0] LVL_NMI = 3'd7;
  localparam logic [LVL_W-1:0] LVL_OFF = 3'd0;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic [BASE_W-1:0] base;
  } irq_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_enc_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LVL_W-1:0]  lvl_wdata_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic              en_we_i,
  input  logic [NCH-1:0]    en_wdata_i,
  output irq_cfg_t          cfg_o,
  output logic [NCH-1:0]    en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      en_o  <= '0;
    end else begin
      if (cfg_we_i) begin
        cfg_o.lvl  <= lvl_wdata_i;
        cfg_o.base <= base_wdata_i;
      end
      if (en_we_i) en_o <= en_wdata_i;
    end
  end

  a_r1_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_o));
  a_r1_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_o));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NCH = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] pend_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;  // new pulse beats clear
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end

  a_r9_set_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));
  a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  a_r8_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(set_i | clr_i)) == ($past(pend_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NCH   = 16,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]   active_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NCH-1:0]   grant_o
);
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    grant_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (active_i[i]) begin
        any_o   = 1'b1;
        idx_o   = IDX_W'(i);
        grant_o = NCH'(1) << i;
      end
    end
  end

  always_comb begin
    a_r7_onehot: assert ($onehot0(grant_o));
    if (any_o) begin
      a_r7_lowest: assert (((grant_o - NCH'(1)) & active_i) == '0);
    end
  end
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import irq_enc_pkg::*;
#(
  parameter int NCH = 16,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int VEC_W = BASE_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LVL_W-1:0]  lvl_wdata_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic              en_we_i,
  input  logic [NCH-1:0]    en_wdata_i,
  input  logic [NCH-1:0]    req_i,
  input  logic              ack_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              nmi_o,
  output logic [VEC_W-1:0]  vec_o
);
  irq_cfg_t         cfg;
  logic [NCH-1:0]   en;
  logic [NCH-1:0]   pend;
  logic [NCH-1:0]   active;
  logic [NCH-1:0]   grant;
  logic [NCH-1:0]   clr;
  logic             any;
  logic [IDX_W-1:0] idx;

  irq_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .lvl_wdata_i, .base_wdata_i,
    .en_we_i, .en_wdata_i, .cfg_o(cfg), .en_o(en)
  );

  irq_pend_bank #(.NCH(NCH)) u_pend (
    .clk_i, .rst_ni, .set_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  assign active = pend & en;

  irq_prio_enc #(.NCH(NCH)) u_prio (
    .active_i(active), .any_o(any), .idx_o(idx), .grant_o(grant)
  );

  assign clr   = ack_i ? grant : '0;
  assign lvl_o = any ? cfg.lvl : LVL_OFF;
  assign nmi_o = (lvl_o == LVL_NMI);
  assign vec_o = {cfg.base, idx};

  a_r3_level_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.lvl == LVL_OFF) |-> (lvl_o == LVL_OFF));
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & en) == '0) |-> (lvl_o == LVL_OFF));
  a_r4_nmi_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (cfg.lvl == LVL_NMI && (pend & en) != '0));
  a_r10_empty_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (pend & en) == '0 && req_i == '0) |=> $stable(pend));
  a_r6_vec_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[VEC_W-1 -: BASE_W] == cfg.base);
endmodule

// File: tb/irq_vec_enc_tb.sv
module irq_vec_enc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  lvl_wdata_i = '0;
  logic [3:0]  base_wdata_i = '0;
  logic        en_we_i = 1'b0;
  logic [15:0] en_wdata_i = '0;
  logic [15:0] req_i = '0;
  logic        ack_i = 1'b0;
  logic [2:0]  lvl_o;
  logic        nmi_o;
  logic [7:0]  vec_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  irq_vec_enc #(.NCH(16)) u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .lvl_wdata_i, .base_wdata_i,
    .en_we_i, .en_wdata_i, .req_i, .ack_i, .lvl_o, .nmi_o, .vec_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] l, input logic [3:0] b);
    @(negedge clk_i); cfg_we_i = 1'b1; lvl_wdata_i = l; base_wdata_i = b;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic wr_en(input logic [15:0] m);
    @(negedge clk_i); en_we_i = 1'b1; en_wdata_i = m;
    @(negedge clk_i); en_we_i = 1'b0;
  endtask

  task automatic pulse_req(input logic [15:0] m);
    @(negedge clk_i); req_i = m;
    @(negedge clk_i); req_i = '0;
  endtask

  task automatic do_ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 lvl reset", lvl_o, 0);
    chk("R1 nmi reset", nmi_o, 0);
    chk("R1 vec reset", vec_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // enables reset to zero: request must not show
    pulse_req(16'h0010);
    chk("R1 en reset blocks", lvl_o, 0);
    // level resets to zero: enabled request still quiet
    wr_en(16'hFFFF);
    chk("R1 lvl field reset", lvl_o, 0);
    chk("R1 base reset vec", vec_o, 8'h04);
    do_ack();
    chk("R8 cleared", vec_o, 8'h00);

    // single-channel sweep
    wr_cfg(3'd5, 4'hA);
    for (int i = 0; i < 16; i++) begin
      pulse_req(16'(1) << i);
      chk("R2 lvl single", lvl_o, 5);
      chk("R6 vec single", vec_o, {4'hA, 4'(i)});
      do_ack();
      chk("R8 single cleared", lvl_o, 0);
    end

    // priority over every pair
    wr_cfg(3'd2, 4'h6);
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        pulse_req((16'(1) << i) | (16'(1) << j));
        chk("R7 lower wins", vec_o, {4'h6, 4'(i)});
        do_ack();
        chk("R8 other kept", vec_o, {4'h6, 4'(j)});
        chk("R2 lvl remains", lvl_o, 2);
        do_ack();
        chk("R8 pair cleared", lvl_o, 0);
      end
    end

    // level sweep
    for (int l = 0; l < 8; l++) begin
      wr_cfg(3'(l), 4'h3);
      pulse_req(16'h0020);
      chk(l == 0 ? "R3 level off" : "R2 level value", lvl_o, l);
      chk("R4 nmi flag", nmi_o, (l == 7) ? 1 : 0);
      do_ack();
      chk("R4 nmi drops", nmi_o, 0);
    end

    // enable gating and retained pending
    wr_cfg(3'd4, 4'hC);
    wr_en(16'h0200);
    pulse_req(16'h0208);
    chk("R5 masked lower loses", vec_o, 8'hC9);
    do_ack();
    chk("R5 masked no level", lvl_o, 0);
    wr_en(16'h0008);
    chk("R11 enable raises", lvl_o, 4);
    chk("R11 vec after enable", vec_o, 8'hC3);
    do_ack();
    chk("R11 cleared", lvl_o, 0);

    // ack with nothing pending
    wr_en(16'hFFFF);
    pulse_req(16'h0000);
    @(negedge clk_i); ack_i = 1'b1;
    #1 chk("R10 empty vec", vec_o, 8'hC0);
    @(negedge clk_i); ack_i = 1'b0;
    chk("R10 no state", lvl_o, 0);
    // disabled pending survives ack
    wr_en(16'h0000);
    pulse_req(16'h0001);
    do_ack();
    wr_en(16'h0001);
    chk("R10 disabled kept", lvl_o, 4);

    // set and ack in same cycle
    @(negedge clk_i); ack_i = 1'b1; req_i = 16'h0001;
    @(negedge clk_i); ack_i = 1'b0; req_i = '0;
    chk("R9 set beats clear", lvl_o, 4);
    chk("R9 vec kept", vec_o, 8'hC0);
    do_ack();
    chk("R9 final clear", lvl_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule